// File: doc/BRIEF.md
# Multi-Policy Page Replacement Selector

This block tracks which virtual pages occupy a small, fully associative pool of physical frames. Each cycle it may accept one page reference. One cycle later it answers with one of three outcomes. A hit means the page is already resident. A fill means the page was placed in a frame that was still empty. An eviction means a resident page was replaced, and the answer names that page.

When every frame is occupied, the victim is picked by one of four policies. Each frame keeps its own page tag and occupancy bit, its place in the order of loading, its place in the order of use, and a saturating use counter. The policy is sampled only on cycles with no reference, so a burst of references always runs under a single policy.

Top module: `page_repl_selector`

## Requirements
- R1: After reset every frame is empty, `rsp_valid` is low and the active policy is first-in-first-out (code 0).
- R2: Every cycle with `req_valid` high gives exactly one response, with `rsp_valid` high, on the following cycle. A cycle with `req_valid` low gives no response.
- R3: A non-resident page with an empty frame available goes into the lowest-index empty frame, with `rsp_hit`=0, `rsp_evict`=0 and `rsp_victim`=0. The number of occupied frames never decreases.
- R4: A resident page gives `rsp_hit`=1, `rsp_evict`=0, `rsp_victim`=0, and `rsp_frame` set to the frame that holds it.
- R5: A non-resident page with all frames full gives `rsp_evict`=1, the replaced page on `rsp_victim`, and its frame on `rsp_frame`. The new page then occupies that frame.
- R6: Policy code 0 evicts the resident page that was loaded earliest. Hits do not change the loading order.
- R7: Policy code 1 evicts the resident page whose latest reference (hit or load) is oldest.
- R8: Policy code 2 evicts the resident page with the smallest use count. A load sets the count to 1 and each hit adds 1. On a tie, the least recently referenced of the tied pages is chosen.
- R9: Policy code 3 evicts the resident page referenced most recently.
- R10: Use counters saturate at 2^CNT_W-1 and never wrap.
- R11: `cfg_policy` is captured only on cycles with `req_valid` low. Changes made while references are streaming have no effect until the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_policy | input | 2 | Requested policy: 0 FIFO, 1 LRU, 2 LFU, 3 MRU |
| req_valid | input | 1 | A page reference is presented this cycle |
| req_page | input | PAGE_W | Virtual page number of the reference |
| rsp_valid | output | 1 | Response for the previous cycle's reference |
| rsp_hit | output | 1 | Page was already resident |
| rsp_evict | output | 1 | A resident page was replaced |
| rsp_victim | output | PAGE_W | Replaced page number (zero when no eviction) |
| rsp_frame | output | clog2(NUM_FRAMES) | Frame that was hit, filled or reused |

## Verification
The bound checker watches, on every cycle, the properties that hold regardless of policy. It checks that a response follows each reference and that none appears otherwise. It also checks that a hit never reports an eviction, that an eviction happens only when the pool is full, that a fill adds exactly one occupied frame, that hits leave the loading order untouched, and that the active policy stays fixed while references stream. Whether the right victim was chosen depends on the whole reference history, so only the bench scenarios can show it. They replay one reference string under each of the four policies, drive a counter-saturation case under least-frequently-used, and change the policy in the middle of a burst. Each response is compared against a timestamp-based model.

// File: rtl/prs_pkg.sv
package prs_pkg;

    typedef enum logic [1:0] {
        POL_FIFO = 2'd0,
        POL_LRU  = 2'd1,
        POL_LFU  = 2'd2,
        POL_MRU  = 2'd3
    } policy_e;

endpackage

// File: rtl/prs_tag_match.sv
module prs_tag_match #(
    parameter int N      = 4,
    parameter int PAGE_W = 8,
    parameter int IW     = 2
) (
    input  logic [N-1:0]             valid_i,
    input  logic [N-1:0][PAGE_W-1:0] tag_i,
    input  logic [PAGE_W-1:0]        page_i,
    output logic                     hit_o,
    output logic [IW-1:0]            idx_o
);

    logic [N-1:0] eq;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign eq[g] = valid_i[g] && (tag_i[g] == page_i);
    end

    assign hit_o = |eq;

    // Lowest index wins (tags are unique, so at most one bit is set).
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (eq[i]) idx_o = IW'(i);
        end
    end

endmodule

// File: rtl/prs_rank_update.sv
module prs_rank_update #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0][IW-1:0] rank_i,
    input  logic                 touch_i,
    input  logic [IW-1:0]        idx_i,
    output logic [N-1:0][IW-1:0] rank_o
);

    // Ranks form a permutation of 0..N-1. Touching a frame moves it to
    // rank 0, and every frame that was ahead of it slides back one place.
    always_comb begin
        rank_o = rank_i;
        if (touch_i) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == idx_i) begin
                    rank_o[i] = '0;
                end else if (rank_i[i] < rank_i[idx_i]) begin
                    rank_o[i] = rank_i[i] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/prs_victim_select.sv
module prs_victim_select
    import prs_pkg::*;
#(
    parameter int N     = 4,
    parameter int IW    = 2,
    parameter int CNT_W = 3
) (
    input  policy_e                 policy_i,
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][IW-1:0]    fifo_rank_i,
    input  logic [N-1:0][IW-1:0]    lru_rank_i,
    input  logic [N-1:0][CNT_W-1:0] cnt_i,
    output logic                    full_o,
    output logic [IW-1:0]           idx_o
);

    localparam logic [IW-1:0] LAST_RANK = IW'(N - 1);

    logic [IW-1:0] free_idx;
    logic [IW-1:0] fifo_idx;
    logic [IW-1:0] lru_idx;
    logic [IW-1:0] mru_idx;
    logic [IW-1:0] lfu_idx;

    assign full_o = &valid_i;

    always_comb begin
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid_i[i]) free_idx = IW'(i);
        end
    end

    always_comb begin
        fifo_idx = '0;
        lru_idx  = '0;
        mru_idx  = '0;
        for (int i = 0; i < N; i++) begin
            if (fifo_rank_i[i] == LAST_RANK) fifo_idx = IW'(i);
            if (lru_rank_i[i] == LAST_RANK)  lru_idx  = IW'(i);
            if (lru_rank_i[i] == '0)         mru_idx  = IW'(i);
        end
    end

    // Fewest uses; ties go to the older recency rank. Ranks are distinct,
    // so a strict comparison leaves the lowest index on any residual tie.
    always_comb begin
        lfu_idx = '0;
        for (int i = 1; i < N; i++) begin
            if ((cnt_i[i] < cnt_i[lfu_idx]) ||
                ((cnt_i[i] == cnt_i[lfu_idx]) &&
                 (lru_rank_i[i] > lru_rank_i[lfu_idx]))) begin
                lfu_idx = IW'(i);
            end
        end
    end

    always_comb begin
        if (!full_o) begin
            idx_o = free_idx;
        end else begin
            case (policy_i)
                POL_FIFO: idx_o = fifo_idx;
                POL_LRU:  idx_o = lru_idx;
                POL_LFU:  idx_o = lfu_idx;
                POL_MRU:  idx_o = mru_idx;
                default:  idx_o = fifo_idx;
            endcase
        end
    end

endmodule

// File: rtl/page_repl_selector.sv
module page_repl_selector
    import prs_pkg::*;
#(
    parameter  int NUM_FRAMES = 4,
    parameter  int PAGE_W     = 8,
    parameter  int CNT_W      = 3,
    localparam int IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_policy,
    input  logic              req_valid,
    input  logic [PAGE_W-1:0] req_page,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic              rsp_evict,
    output logic [PAGE_W-1:0] rsp_victim,
    output logic [IDX_W-1:0]  rsp_frame
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        logic [NUM_FRAMES-1:0]             valid;
        logic [NUM_FRAMES-1:0][PAGE_W-1:0] tag;
        logic [NUM_FRAMES-1:0][IDX_W-1:0]  fifo_rank;
        logic [NUM_FRAMES-1:0][IDX_W-1:0]  lru_rank;
        logic [NUM_FRAMES-1:0][CNT_W-1:0]  cnt;
        policy_e                           policy;
        logic                              rsp_valid;
        logic                              rsp_hit;
        logic                              rsp_evict;
        logic [PAGE_W-1:0]                 rsp_page;
        logic [IDX_W-1:0]                  rsp_frame;
    } state_t;

    state_t state_q;
    state_t state_d;

    logic                             hit;
    logic [IDX_W-1:0]                 hit_idx;
    logic                             full;
    logic [IDX_W-1:0]                 vic_idx;
    logic [IDX_W-1:0]                 tgt_idx;
    logic [NUM_FRAMES-1:0][IDX_W-1:0] fifo_next;
    logic [NUM_FRAMES-1:0][IDX_W-1:0] lru_next;

    function automatic state_t reset_state();
        state_t s;
        s        = '0;
        s.policy = POL_FIFO;
        for (int i = 0; i < NUM_FRAMES; i++) begin
            s.fifo_rank[i] = IDX_W'(i);
            s.lru_rank[i]  = IDX_W'(i);
        end
        return s;
    endfunction

    prs_tag_match #(
        .N      (NUM_FRAMES),
        .PAGE_W (PAGE_W),
        .IW     (IDX_W)
    ) u_match (
        .valid_i (state_q.valid),
        .tag_i   (state_q.tag),
        .page_i  (req_page),
        .hit_o   (hit),
        .idx_o   (hit_idx)
    );

    prs_victim_select #(
        .N     (NUM_FRAMES),
        .IW    (IDX_W),
        .CNT_W (CNT_W)
    ) u_victim (
        .policy_i    (state_q.policy),
        .valid_i     (state_q.valid),
        .fifo_rank_i (state_q.fifo_rank),
        .lru_rank_i  (state_q.lru_rank),
        .cnt_i       (state_q.cnt),
        .full_o      (full),
        .idx_o       (vic_idx)
    );

    assign tgt_idx = hit ? hit_idx : vic_idx;

    // Load order moves only when a page is brought in.
    prs_rank_update #(
        .N  (NUM_FRAMES),
        .IW (IDX_W)
    ) u_fifo_order (
        .rank_i  (state_q.fifo_rank),
        .touch_i (req_valid && !hit),
        .idx_i   (tgt_idx),
        .rank_o  (fifo_next)
    );

    // Use order moves on every reference.
    prs_rank_update #(
        .N  (NUM_FRAMES),
        .IW (IDX_W)
    ) u_use_order (
        .rank_i  (state_q.lru_rank),
        .touch_i (req_valid),
        .idx_i   (tgt_idx),
        .rank_o  (lru_next)
    );

    always_comb begin
        state_d           = state_q;
        state_d.rsp_valid = req_valid;
        state_d.rsp_hit   = 1'b0;
        state_d.rsp_evict = 1'b0;
        state_d.rsp_page  = '0;
        state_d.rsp_frame = '0;

        if (!req_valid) begin
            state_d.policy = policy_e'(cfg_policy);
        end else begin
            state_d.rsp_frame = tgt_idx;
            state_d.lru_rank  = lru_next;
            if (hit) begin
                state_d.rsp_hit = 1'b1;
                if (state_q.cnt[tgt_idx] != CNT_MAX) begin
                    state_d.cnt[tgt_idx] = state_q.cnt[tgt_idx] + 1'b1;
                end
            end else begin
                state_d.fifo_rank      = fifo_next;
                state_d.valid[tgt_idx] = 1'b1;
                state_d.tag[tgt_idx]   = req_page;
                state_d.cnt[tgt_idx]   = CNT_ONE;
                if (full) begin
                    state_d.rsp_evict = 1'b1;
                    state_d.rsp_page  = state_q.tag[tgt_idx];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= reset_state();
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid  = state_q.rsp_valid;
    assign rsp_hit    = state_q.rsp_hit;
    assign rsp_evict  = state_q.rsp_evict;
    assign rsp_victim = state_q.rsp_page;
    assign rsp_frame  = state_q.rsp_frame;

endmodule

// File: rtl/prs_checker.sv
module prs_checker #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 rsp_valid,
    input logic                 rsp_hit,
    input logic                 rsp_evict,
    input logic [IW-1:0]        rsp_frame,
    input logic [N-1:0]         frame_valid,
    input logic [N-1:0][IW-1:0] fifo_rank,
    input logic [1:0]           active_policy
);

    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_rsp_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_hit_never_evicts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> !rsp_evict);

    assert_hit_frame_occupied_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> frame_valid[rsp_frame]);

    assert_evict_only_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_evict) |-> (&$past(frame_valid)));

    assert_fill_adds_one_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_evict) |->
        ($countones(frame_valid) == $countones($past(frame_valid)) + 1));

    assert_occupancy_monotonic_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(frame_valid) >= $countones($past(frame_valid)));

    assert_hit_keeps_load_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_hit) |-> (fifo_rank == $past(fifo_rank)));

    assert_policy_held_in_burst_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> $stable(active_policy));

endmodule

bind page_repl_selector prs_checker #(
    .N  (NUM_FRAMES),
    .IW (IDX_W)
) u_prs_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_valid     (rsp_valid),
    .rsp_hit       (rsp_hit),
    .rsp_evict     (rsp_evict),
    .rsp_frame     (rsp_frame),
    .frame_valid   (state_q.valid),
    .fifo_rank     (state_q.fifo_rank),
    .active_policy (state_q.policy)
);

// File: tb/page_repl_selector_tb.sv
`timescale 1ns/1ps
module page_repl_selector_tb;

    localparam int NF   = 4;
    localparam int PW   = 8;
    localparam int CW   = 3;
    localparam int IW   = 2;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_policy = 2'd0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_page = '0;
    logic          rsp_valid;
    logic          rsp_hit;
    logic          rsp_evict;
    logic [PW-1:0] rsp_victim;
    logic [IW-1:0] rsp_frame;

    always #2.5 clk = ~clk;

    page_repl_selector #(
        .NUM_FRAMES (NF),
        .PAGE_W     (PW),
        .CNT_W      (CW)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_policy (cfg_policy),
        .req_valid  (req_valid),
        .req_page   (req_page),
        .rsp_valid  (rsp_valid),
        .rsp_hit    (rsp_hit),
        .rsp_evict  (rsp_evict),
        .rsp_victim (rsp_victim),
        .rsp_frame  (rsp_frame)
    );

    typedef struct {
        logic          hit;
        logic          evict;
        logic [PW-1:0] page;
        logic [IW-1:0] frame;
        string         tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Timestamp model: load time, last-use time and saturating use count.
    logic          mval [NF];
    logic [PW-1:0] mpage[NF];
    int            mload[NF];
    int            muse [NF];
    int            mcnt [NF];
    int            mtime;
    int            mpol;

    function automatic void model_clear();
        for (int i = 0; i < NF; i++) begin
            mval[i] = 1'b0; mpage[i] = '0; mload[i] = 0; muse[i] = 0; mcnt[i] = 0;
        end
        mtime = 0;
        mpol  = 0;
    endfunction

    function automatic void model_ref(logic [PW-1:0] p, string sc);
        exp_t  e;
        int    h = -1;
        int    f = -1;
        string kind;
        mtime++;
        for (int i = 0; i < NF; i++) if (mval[i] && mpage[i] == p && h < 0) h = i;
        e.hit = 1'b0; e.evict = 1'b0; e.page = '0;
        if (h >= 0) begin
            e.hit   = 1'b1;
            e.frame = IW'(h);
            muse[h] = mtime;
            if (mcnt[h] < CMAX) mcnt[h]++;
            kind = "R4 hit";
        end else begin
            for (int i = 0; i < NF; i++) if (!mval[i] && f < 0) f = i;
            if (f >= 0) begin
                kind = "R3 fill";
            end else begin
                f = 0;
                for (int i = 1; i < NF; i++) begin
                    case (mpol)
                        0: if (mload[i] < mload[f]) f = i;
                        1: if (muse[i] < muse[f]) f = i;
                        2: if (mcnt[i] < mcnt[f] ||
                               (mcnt[i] == mcnt[f] && muse[i] < muse[f])) f = i;
                        default: if (muse[i] > muse[f]) f = i;
                    endcase
                end
                e.evict = 1'b1;
                e.page  = mpage[f];
                kind    = "R5 evict";
            end
            e.frame  = IW'(f);
            mval[f]  = 1'b1;
            mpage[f] = p;
            mload[f] = mtime;
            muse[f]  = mtime;
            mcnt[f]  = 1;
        end
        e.tag = {sc, " ", kind};
        exp_q.push_back(e);
    endfunction

    task automatic ref_page(input logic [PW-1:0] p, input string sc);
        @(negedge clk);
        req_valid = 1'b1;
        req_page  = p;
        model_ref(p, sc);
    endtask

    task automatic set_policy(input int p);
        @(negedge clk);
        req_valid  = 1'b0;
        cfg_policy = 2'(p);
        mpol       = p;
    endtask

    // One idle cycle, then confirm no response was produced for it (R2).
    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        mpol      = int'(cfg_policy);
        @(negedge clk);
        mpol = int'(cfg_policy);
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R2 idle cycle: rsp_valid actual=%b expected=0", rsp_valid);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_policy = 2'd0;
        repeat (2) @(negedge clk);
        model_clear();
        rst_n = 1'b1;
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid && !done) begin
            n_cmp++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R2 unexpected response: actual hit=%b evict=%b expected none",
                         rsp_hit, rsp_evict);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_hit !== e.hit || rsp_evict !== e.evict ||
                    rsp_victim !== e.page || rsp_frame !== e.frame) begin
                    n_bad++;
                    $display("FAIL %s: actual hit=%b evict=%b victim=%0d frame=%0d expected hit=%b evict=%b victim=%0d frame=%0d",
                             e.tag, rsp_hit, rsp_evict, rsp_victim, rsp_frame,
                             e.hit, e.evict, e.page, e.frame);
                end
            end
        end
    end

    task automatic run_string(input string sc);
        int seq[17] = '{0, 1, 2, 3, 4, 1, 3, 4, 4, 5, 3, 1, 2, 0, 4, 5, 4};
        foreach (seq[k]) ref_page(PW'(seq[k] + 16), sc);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2 watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R1: reset state seen at the ports
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: rsp_valid actual=%b expected=0", rsp_valid);
        end
        rst_n = 1'b1;

        // R1: no policy set, so FIFO applies from reset
        run_string("R1 R6");
        idle_check();

        do_reset();
        set_policy(0);
        run_string("R6");
        idle_check();

        do_reset();
        set_policy(1);
        run_string("R7");
        idle_check();

        do_reset();
        set_policy(2);
        run_string("R8");
        idle_check();

        do_reset();
        set_policy(3);
        run_string("R9");
        idle_check();

        // R10: saturation under LFU; a wrapping counter would evict page 1
        do_reset();
        set_policy(2);
        for (int k = 1; k <= 4; k++) ref_page(PW'(k), "R10");
        for (int k = 2; k <= 4; k++)
            for (int r = 0; r < 6; r++) ref_page(PW'(k), "R10");
        for (int r = 0; r < 9; r++) ref_page(PW'(1), "R10");
        ref_page(PW'(9), "R10");
        idle_check();

        // R11: policy change during a burst is ignored until an idle cycle
        do_reset();
        set_policy(0);
        for (int k = 1; k <= 4; k++) ref_page(PW'(40 + k), "R11");
        ref_page(PW'(42), "R11");
        cfg_policy = 2'd3;
        ref_page(PW'(50), "R11");
        ref_page(PW'(51), "R11");
        idle_check();
        ref_page(PW'(52), "R11");
        ref_page(PW'(41), "R11");
        idle_check();

        // R2: every accepted reference was answered
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R2 pending responses: actual=%0d expected=0", exp_q.size());
        end
        finish_run();
    end

endmodule